// File: doc/BRIEF.md
# Interrupt vector ring producer

The block takes interrupt events from on-chip sources and stores each one as a 16-byte vector in a circular buffer. The buffer is a local memory addressed in dwords. A byte-granular write pointer marks where the producer has written. A read pointer, loaded by the host through a small register port, marks how far the consumer has got. When the two pointers are equal the ring is empty. When they differ and interrupts are enabled, the block raises an interrupt line.

Events arrive through a valid/ready port. They enter a small FIFO, which stalls the source when it is full. A writer drains the FIFO only while the ring is enabled. It stores the four dwords of a vector on four consecutive cycles and only then publishes the advanced write pointer. If publishing would make the write pointer equal to the read pointer, the ring has overrun unread data. A sticky overflow flag then sets in the top bit of the write-pointer register, and software clears it through a control bit.

A memory read port lets the consumer side see the ring contents. In a larger system this port stands in for the host-visible memory.

Top module: `irq_ring_producer`

## Requirements
- R1: After reset the control, read-pointer and write-pointer registers read 0, the status register reads 2 (idle=1, busy=0), `irq_o` is 0 and `evt_ready_o` is 1.
- R2: Each vector is written at dword index wptr>>2 onward. Dword 0 holds {24'b0, source[7:0]}, dword 1 holds {4'b0, data[27:0]}, dword 2 holds {pasid[15:0], vmid[7:0], ring[7:0]}, and dword 3 is 0.
- R3: Each written vector advances the write pointer (register address 2, bits [PTR_W-1:0]) by 16 bytes, modulo the ring span of 4<<size bytes. Size is the control field at bits [6:2] and gives log2 of the dword count, clamped to the range 2 to MEM_DW_LOG2.
- R4: When an advanced write pointer equals the read pointer, bit 31 of the write-pointer register sets. It stays set through later vectors until a control write with bit 7 = 1. That bit reads back as 0.
- R5: Status bit 1 (register address 3) reads 1 exactly when the read and write pointers are equal.
- R6: `irq_o` is 1 while control bit 1 (interrupt enable) is set and the pointers differ. It falls one cycle after the edge that makes them equal, and it stays 0 while interrupt enable is clear.
- R7: While control bit 0 (ring enable) is clear, no vector is written and the write pointer does not move. Accepted events wait in the FIFO.
- R8: Writes to the read pointer (address 1) and write pointer (address 2) load the written value ANDed with the ring span mask and with 16-byte alignment.
- R9: Status bit 0 (busy) is 1 while the FIFO holds an event or a vector is partly written.
- R10: The event FIFO holds FIFO_DEPTH events. When it is full, `evt_ready_o` is 0 and further events are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | FIFO can accept an event |
| evt_src_i | input | 8 | Source id |
| evt_data_i | input | 28 | Source data |
| evt_ring_i | input | 8 | Ring id |
| evt_vmid_i | input | 8 | Virtual machine id |
| evt_pasid_i | input | 16 | Process address space id |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 read pointer, 2 write pointer, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_raddr_i | input | MEM_DW_LOG2 | Ring dword index to inspect |
| mem_rdata_o | output | 32 | Ring dword at mem_raddr_i |
| irq_o | output | 1 | Interrupt pending |

## Verification
The bench goes after the following corner cases:
- It fills the FIFO while the ring is disabled. A design that leaks writes would move the write pointer, and one with wrong backpressure would accept a fifth event.
- On a small ring it wraps the write pointer onto the read pointer. A design with a faulty mask or overflow compare would miss the sticky flag or corrupt the wrap address.
- It writes another vector with the flag still set, to show the flag does not self-clear, and then clears it through the control bit.
- It times the fall of the interrupt after a read-pointer catch-up and checks that masking holds the line low. An off-by-one register stage would show here.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;
  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  src;
  } irq_vec_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_RPTR = 2'd1;
  localparam logic [1:0] REG_WPTR = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam int CTL_RING_EN  = 0;
  localparam int CTL_INTR_EN  = 1;
  localparam int CTL_SIZE_LSB = 2;
  localparam int CTL_SIZE_W   = 5;
  localparam int CTL_OVF_CLR  = 7;
  localparam int WPTR_OVF_BIT = 31;

  localparam int VEC_BYTES = 16;

  typedef enum logic [2:0] {WR_IDLE, WR_D0, WR_D1, WR_D2, WR_D3} wr_state_e;
endpackage

// File: rtl/irq_evt_fifo.sv
module irq_evt_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [AW-1:0] wr_idx_q, rd_idx_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign ready_o = (cnt_q != CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i && ready_o;
  assign do_pop  = pop_i && valid_o;
  assign data_o  = store_q[rd_idx_q];

  always_ff @(posedge clk_i) begin
    if (do_push) store_q[wr_idx_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_idx_q <= (wr_idx_q == AW'(DEPTH - 1)) ? '0 : wr_idx_q + 1'b1;
      if (do_pop)  rd_idx_q <= (rd_idx_q == AW'(DEPTH - 1)) ? '0 : rd_idx_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R10: an accepted event without a pop grows occupancy by exactly one
  a_r10_fill_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_push && !do_pop) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R10: a full FIFO accepts nothing
  a_r10_no_overfill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DEPTH) && !do_pop) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/irq_vec_writer.sv
module irq_vec_writer
  import irq_ring_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_en_i,
  input  logic              vld_i,
  input  irq_vec_t          vec_i,
  input  logic [MEM_AW+1:0] wptr_i,
  output logic              pop_o,
  output logic              we_o,
  output logic [MEM_AW-1:0] waddr_o,
  output logic [31:0]       wdata_o,
  output logic              done_o,
  output logic              busy_o
);
  wr_state_e         state_q;
  irq_vec_t          vec_q;
  logic [MEM_AW-1:0] base_q;
  logic [1:0]        word;

  assign pop_o  = (state_q == WR_IDLE) && ring_en_i && vld_i;
  assign busy_o = (state_q != WR_IDLE);
  assign we_o   = busy_o;
  assign done_o = (state_q == WR_D3);

  always_comb begin
    word    = 2'd0;
    wdata_o = 32'h0;
    case (state_q)
      WR_D0: begin word = 2'd0; wdata_o = {24'h0, vec_q.src}; end
      WR_D1: begin word = 2'd1; wdata_o = {4'h0, vec_q.data}; end
      WR_D2: begin word = 2'd2; wdata_o = {vec_q.pasid, vec_q.vmid, vec_q.ring}; end
      WR_D3: begin word = 2'd3; wdata_o = 32'h0; end
      default: ;
    endcase
  end

  assign waddr_o = base_q + MEM_AW'(word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      vec_q   <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (pop_o) begin
          vec_q   <= vec_i;
          base_q  <= wptr_i[MEM_AW+1:2];
          state_q <= WR_D0;
        end
        WR_D0:   state_q <= WR_D1;
        WR_D1:   state_q <= WR_D2;
        WR_D2:   state_q <= WR_D3;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  // R7: no vector starts while the ring is disabled
  a_r7_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WR_IDLE && !ring_en_i) |=> (state_q == WR_IDLE));
  // R2: a started vector is always completed over four consecutive writes
  a_r2_four_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WR_D0) |=> (we_o && waddr_o == $past(waddr_o) + MEM_AW'(1)));
endmodule

// File: rtl/irq_ring_mem.sv
module irq_ring_mem #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  localparam int N = 1 << AW;
  logic [31:0] mem_q [N];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/irq_ring_producer.sv
module irq_ring_producer
  import irq_ring_pkg::*;
#(
  parameter int MEM_DW_LOG2 = 8,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   evt_valid_i,
  output logic                   evt_ready_o,
  input  logic [7:0]             evt_src_i,
  input  logic [27:0]            evt_data_i,
  input  logic [7:0]             evt_ring_i,
  input  logic [7:0]             evt_vmid_i,
  input  logic [15:0]            evt_pasid_i,
  input  logic                   reg_we_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  input  logic [MEM_DW_LOG2-1:0] mem_raddr_i,
  output logic [31:0]            mem_rdata_o,
  output logic                   irq_o
);
  localparam int PTR_W = MEM_DW_LOG2 + 2;
  localparam int VEC_W = $bits(irq_vec_t);
  localparam logic [CTL_SIZE_W-1:0] MAX_SZ = CTL_SIZE_W'(MEM_DW_LOG2);
  localparam logic [CTL_SIZE_W-1:0] MIN_SZ = CTL_SIZE_W'(2);

  logic                  ring_en_q, intr_en_q, ovf_q, irq_q;
  logic [CTL_SIZE_W-1:0] size_q, eff_size;
  logic [PTR_W-1:0]      rptr_q, wptr_q, wptr_adv, ptr_mask, load_mask;
  logic [PTR_W:0]        span;

  logic           wr_ctrl, wr_rptr, wr_wptr, ovf_clr;
  logic           fifo_vld, pop, mem_we, wr_done, wr_busy;
  logic [VEC_W-1:0] fifo_out;
  irq_vec_t       in_vec;
  logic [MEM_DW_LOG2-1:0] mem_waddr;
  logic [31:0]    mem_wdata;

  assign in_vec = '{pasid: evt_pasid_i, vmid: evt_vmid_i, ring: evt_ring_i,
                    data: evt_data_i, src: evt_src_i};

  irq_evt_fifo #(.W(VEC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (evt_valid_i),
    .ready_o(evt_ready_o),
    .data_i (in_vec),
    .pop_i  (pop),
    .valid_o(fifo_vld),
    .data_o (fifo_out)
  );

  irq_vec_writer #(.MEM_AW(MEM_DW_LOG2)) u_writer (
    .clk_i, .rst_ni,
    .ring_en_i(ring_en_q),
    .vld_i    (fifo_vld),
    .vec_i    (irq_vec_t'(fifo_out)),
    .wptr_i   (wptr_q),
    .pop_o    (pop),
    .we_o     (mem_we),
    .waddr_o  (mem_waddr),
    .wdata_o  (mem_wdata),
    .done_o   (wr_done),
    .busy_o   (wr_busy)
  );

  irq_ring_mem #(.AW(MEM_DW_LOG2)) u_mem (
    .clk_i,
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr_i),
    .rdata_o(mem_rdata_o)
  );

  // ring span in bytes is 4 << size
  always_comb begin
    if (size_q > MAX_SZ)      eff_size = MAX_SZ;
    else if (size_q < MIN_SZ) eff_size = MIN_SZ;
    else                      eff_size = size_q;
  end
  assign span      = (PTR_W+1)'(1) << (eff_size + CTL_SIZE_W'(2));
  assign ptr_mask  = PTR_W'(span - (PTR_W+1)'(1));
  assign load_mask = ptr_mask & ~PTR_W'(VEC_BYTES - 1);
  assign wptr_adv  = (wptr_q + PTR_W'(VEC_BYTES)) & ptr_mask;

  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_rptr = reg_we_i && (reg_addr_i == REG_RPTR);
  assign wr_wptr = reg_we_i && (reg_addr_i == REG_WPTR);
  assign ovf_clr = wr_ctrl && reg_wdata_i[CTL_OVF_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_en_q <= 1'b0;
      intr_en_q <= 1'b0;
      size_q    <= '0;
      rptr_q    <= '0;
      wptr_q    <= '0;
      ovf_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ring_en_q <= reg_wdata_i[CTL_RING_EN];
        intr_en_q <= reg_wdata_i[CTL_INTR_EN];
        size_q    <= reg_wdata_i[CTL_SIZE_LSB +: CTL_SIZE_W];
      end
      if (wr_rptr) rptr_q <= reg_wdata_i[PTR_W-1:0] & load_mask;
      if (wr_wptr)      wptr_q <= reg_wdata_i[PTR_W-1:0] & load_mask;
      else if (wr_done) wptr_q <= wptr_adv;
      // overrun set wins over a clear in the same cycle
      if (wr_done && (wptr_adv == rptr_q)) ovf_q <= 1'b1;
      else if (ovf_clr)                    ovf_q <= 1'b0;
      irq_q <= intr_en_q && (rptr_q != wptr_q);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = 32'h0;
    case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[CTL_RING_EN] = ring_en_q;
        reg_rdata_o[CTL_INTR_EN] = intr_en_q;
        reg_rdata_o[CTL_SIZE_LSB +: CTL_SIZE_W] = size_q;
      end
      REG_RPTR: reg_rdata_o[PTR_W-1:0] = rptr_q;
      REG_WPTR: begin
        reg_rdata_o[PTR_W-1:0]    = wptr_q;
        reg_rdata_o[WPTR_OVF_BIT] = ovf_q;
      end
      default: begin
        reg_rdata_o[0] = fifo_vld || wr_busy;
        reg_rdata_o[1] = (rptr_q == wptr_q);
      end
    endcase
  end

  // R3: a published vector moves the pointer by one vector inside the span
  a_r3_wptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_done && !wr_wptr && !wr_ctrl) |=>
      (((wptr_q - $past(wptr_q)) & $past(ptr_mask)) == (PTR_W'(VEC_BYTES) & $past(ptr_mask))));
  // R4: overflow flag is sticky until cleared
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R6: masked interrupts keep the line low
  a_r6_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intr_en_q |=> !irq_o);
  // R7: pointer is frozen while the ring is off and software leaves it alone
  a_r7_wptr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ring_en_q && !wr_busy && !wr_wptr) |=> $stable(wptr_q));
endmodule

// File: tb/irq_ring_producer_bench.sv
`timescale 1ns/1ps
module irq_ring_producer_bench;
  import irq_ring_pkg::*;

  localparam int MEM_DW_LOG2 = 8;
  localparam int PTR_W = MEM_DW_LOG2 + 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic evt_valid_i = 1'b0, evt_ready_o;
  logic [7:0] evt_src_i = '0, evt_ring_i = '0, evt_vmid_i = '0;
  logic [27:0] evt_data_i = '0;
  logic [15:0] evt_pasid_i = '0;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o, mem_rdata_o;
  logic [MEM_DW_LOG2-1:0] mem_raddr_i = '0;
  logic irq_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  irq_vec_t exp_q[$];
  int model_wptr = 0;
  int model_mask = 1023;

  always #10 clk_i = ~clk_i;

  irq_ring_producer #(.MEM_DW_LOG2(MEM_DW_LOG2), .FIFO_DEPTH(4)) u_irq_ring_producer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  function automatic irq_vec_t mk_vec(input int i);
    irq_vec_t v;
    v.src   = 8'(8'h40 + i);
    v.data  = 28'(28'h9A5_0C30 ^ (i * 28'h0111_111));
    v.ring  = 8'(i);
    v.vmid  = 8'(8'hF0 - i);
    v.pasid = 16'(16'hC000 | (i * 7));
    return v;
  endfunction

  // driver: offers one event for one cycle; queues it as expected if taken
  task automatic try_push(input irq_vec_t v, output bit ok);
    @(negedge clk_i);
    evt_valid_i = 1'b1;
    evt_src_i = v.src; evt_data_i = v.data; evt_ring_i = v.ring;
    evt_vmid_i = v.vmid; evt_pasid_i = v.pasid;
    #1 ok = evt_ready_o;
    if (ok) exp_q.push_back(v);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  task automatic push(input irq_vec_t v);
    bit ok = 0;
    while (!ok) try_push(v, ok);
  endtask

  // monitor: waits for the producer to go quiet, then compares every queued vector
  task automatic drain();
    logic [31:0] d;
    irq_vec_t v;
    int guard = 0;
    do begin
      reg_rd(REG_STAT, d);
      guard++;
    end while (d[0] && guard < 1000);
    while (exp_q.size() > 0) begin
      v = exp_q.pop_front();
      for (int k = 0; k < 4; k++) begin
        logic [31:0] e;
        case (k)
          0: e = {24'h0, v.src};
          1: e = {4'h0, v.data};
          2: e = {v.pasid, v.vmid, v.ring};
          default: e = 32'h0;
        endcase
        @(negedge clk_i);
        mem_raddr_i = MEM_DW_LOG2'((model_wptr >> 2) + k);
        #1 chk("R2 vector dword", mem_rdata_o, e);
      end
      model_wptr = (model_wptr + 16) & model_mask;
    end
    reg_rd(REG_WPTR, d);
    chk("R3 write pointer", {22'h0, d[PTR_W-1:0]}, 32'(model_wptr));
  endtask

  initial begin
    logic [31:0] d;
    bit ok;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    reg_rd(REG_CTRL, d); chk("R1 ctrl", d, 32'h0);
    reg_rd(REG_RPTR, d); chk("R1 rptr", d, 32'h0);
    reg_rd(REG_WPTR, d); chk("R1 wptr", d, 32'h0);
    reg_rd(REG_STAT, d); chk("R1 status", d, 32'h2);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 ready", {31'h0, evt_ready_o}, 32'h1);

    // R7/R10: ring off, size 8; four events fill the FIFO, fifth refused
    reg_wr(REG_CTRL, 32'h2 | (32'd8 << 2));
    for (int i = 0; i < 4; i++) begin
      try_push(mk_vec(i), ok);
      chk("R10 accept while room", {31'h0, ok}, 32'h1);
    end
    try_push(mk_vec(99), ok);
    chk("R10 refuse when full", {31'h0, ok}, 32'h0);
    repeat (4) @(negedge clk_i);
    reg_rd(REG_WPTR, d); chk("R7 wptr frozen while disabled", d, 32'h0);
    reg_rd(REG_STAT, d); chk("R9 busy with queued events", {31'h0, d[0]}, 32'h1);

    // enable ring: four vectors land, then a fifth
    reg_wr(REG_CTRL, 32'h3 | (32'd8 << 2));
    drain();
    push(mk_vec(4));
    drain();
    reg_rd(REG_STAT, d); chk("R5 R9 status pointers differ", d, 32'h0);
    chk("R6 irq while pending", {31'h0, irq_o}, 32'h1);

    // R6: catch up; irq falls one cycle after the rptr edge
    reg_wr(REG_RPTR, 32'd80);
    chk("R6 irq still high right after rptr write", {31'h0, irq_o}, 32'h1);
    @(negedge clk_i);
    chk("R6 irq low one cycle later", {31'h0, irq_o}, 32'h0);
    reg_rd(REG_STAT, d); chk("R5 idle when equal", d, 32'h2);

    // R6: masked interrupts stay low with pending data
    reg_wr(REG_CTRL, 32'h1 | (32'd8 << 2));
    push(mk_vec(5));
    drain();
    repeat (2) @(negedge clk_i);
    chk("R6 irq masked", {31'h0, irq_o}, 32'h0);

    // R8: pointer reset and masking with size 4 (64-byte span)
    reg_wr(REG_CTRL, 32'd4 << 2);
    reg_wr(REG_WPTR, 32'h0);
    reg_wr(REG_RPTR, 32'h3B7);
    reg_rd(REG_RPTR, d); chk("R8 rptr masked and aligned", d, 32'h30);
    reg_wr(REG_RPTR, 32'h0);
    reg_rd(REG_RPTR, d); chk("R8 rptr zero", d, 32'h0);
    reg_rd(REG_WPTR, d); chk("R8 wptr zero", d, 32'h0);
    model_wptr = 0; model_mask = 63;

    // R3/R4: wrap and overflow on the 64-byte ring
    reg_wr(REG_CTRL, 32'h3 | (32'd4 << 2));
    for (int i = 10; i < 13; i++) push(mk_vec(i));
    drain();
    reg_rd(REG_WPTR, d); chk("R4 no overflow before wrap", d, 32'd48);
    push(mk_vec(13));
    drain();
    reg_rd(REG_WPTR, d); chk("R4 R3 overflow on wrap to rptr", d, 32'h8000_0000);
    push(mk_vec(14));
    drain();
    reg_rd(REG_WPTR, d); chk("R4 overflow sticky", d, 32'h8000_0010);
    reg_wr(REG_CTRL, 32'h83 | (32'd4 << 2));
    reg_rd(REG_WPTR, d); chk("R4 overflow cleared", d, 32'h10);
    reg_rd(REG_CTRL, d); chk("R4 clear bit reads zero", d, 32'h3 | (32'd4 << 2));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1-timeout actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule